// File: doc/BRIEF.md
# Bit-Serial Stream Cipher Core with Linearization Fault Mode

This block is a keystream generator for a 288-bit shift-register stream cipher. It emits one keystream bit per clock and XORs it with a serial data bit. The same path encrypts plaintext and decrypts ciphertext. A load strobe captures an 80-bit secret key and an 80-bit public IV and mixes them with fixed constants. A warm-up phase follows in which the state is clocked without producing output. After warm-up, each clock with the enable high yields one valid output bit.

A static fault-mode input forces the three two-input AND products of the state update to constant zero. The update is then a purely affine function over GF(2). This lets the core stand in for a cipher whose nonlinear gates an attacker has overwritten. Analysis flows can then study what such a linearized keystream reveals.

Top module: `lfk_core`

## Requirements
- R1: After synchronous reset, and until the first load, `ks_valid` and `dout` stay 0 whatever `en` and `din` do.
- R2: A load places key bit i in state position i+1 and IV bit i in position 94+i (positions 1..288). Positions 286, 287 and 288 become 1 and every other position becomes 0.
- R3: After the load edge the core clocks its state exactly 1152 times with `ks_valid` low, ignoring `en`. `ks_valid` can rise only after the 1152nd update edge.
- R4: After warm-up, `ks_valid` equals `en`. While `en` is low the state does not advance, so the keystream resumes where it stopped.
- R5: When `ks_valid` is 1, `dout` = `din` XOR z, where z is the current keystream bit; when it is 0, `dout` is 0. Feeding `dout` back through a core with equal key and IV recovers `din`.
- R6: With `lin_mode` = 0, each step computes t1 = s66^s93, t2 = s162^s177 and t3 = s243^s288, and z = t1^t2^t3. The feedback adds (s91&s92)^s171 to t1, (s175&s176)^s264 to t2 and (s286&s287)^s69 to t3. The state then shifts by one position, with t3 entering s1, t1 entering s94 and t2 entering s178.
- R7: With `lin_mode` = 1, the three AND products in R6 are replaced by 0 and the rest of the update is unchanged.
- R8: With `lin_mode` = 1, for any loads A, B, C, the keystream from key^iv pair A^B^C equals the XOR of the three keystreams.
- R9: A load during warm-up or generation restarts initialization with the new key and IV. The R3 warm-up applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key | input | 80 | Secret key, sampled on load |
| iv | input | 80 | Public IV, sampled on load |
| load | input | 1 | Start initialization with key and iv |
| en | input | 1 | Request one output bit this cycle (after warm-up) |
| lin_mode | input | 1 | Force nonlinear AND terms to zero |
| din | input | 1 | Plaintext or ciphertext bit |
| dout | output | 1 | din XOR keystream when valid, else 0 |
| ks_valid | output | 1 | dout carries a keystream-combined bit |

## Verification
The assertions assume `lin_mode` is held constant from a load through the end of that keystream. They also assume `load` is a single-cycle strobe that is not needed while reset is high. The stimulus changes `lin_mode` only in the cycle before a load and pulses `load` for one clock. The bench's reference model and its GF(2) superposition check rely on those same assumptions. The enable pauses fall only after warm-up, where R4 defines their effect.

// File: rtl/lfk_pkg.sv
package lfk_pkg;
    localparam int STATE_W  = 288;
    localparam int KEY_W    = 80;
    localparam int IV_W     = 80;
    localparam int IV_POS   = 93;     // zero-based start of IV field (position 94)
    localparam int WARMUP   = 4 * STATE_W;
    localparam int CNT_W    = $clog2(WARMUP);

    // register segment lengths (positions 1..93, 94..177, 178..288)
    localparam int SEG_A = 93;
    localparam int SEG_B = 84;
    localparam int SEG_C = STATE_W - SEG_A - SEG_B;

    typedef logic [STATE_W-1:0] state_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WARM = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef struct packed {
        state_t nxt;
        logic   z;
    } step_t;

    // one-based position to zero-based bit index
    function automatic int pos(input int p);
        return p - 1;
    endfunction

    function automatic state_t seed(input logic [KEY_W-1:0] k,
                                    input logic [IV_W-1:0]  v);
        state_t s;
        s = '0;
        s[KEY_W-1:0]              = k;
        s[IV_POS +: IV_W]         = v;
        s[STATE_W-1 -: 3]         = 3'b111;
        return s;
    endfunction
endpackage

// File: rtl/lfk_round.sv
module lfk_round
    import lfk_pkg::*;
(
    input  state_t s,
    input  logic   lin,
    output step_t  o
);
    logic t1, t2, t3;
    logic a1, a2, a3;

    always_comb begin
        a1 = s[pos(91)]  & s[pos(92)]  & ~lin;
        a2 = s[pos(175)] & s[pos(176)] & ~lin;
        a3 = s[pos(286)] & s[pos(287)] & ~lin;

        t1 = s[pos(66)]  ^ s[pos(93)];
        t2 = s[pos(162)] ^ s[pos(177)];
        t3 = s[pos(243)] ^ s[pos(288)];
        o.z = t1 ^ t2 ^ t3;

        t1 = t1 ^ a1 ^ s[pos(171)];
        t2 = t2 ^ a2 ^ s[pos(264)];
        t3 = t3 ^ a3 ^ s[pos(69)];

        o.nxt = {s[STATE_W-2 -: SEG_C-1], t2,
                 s[SEG_A+SEG_B-2 -: SEG_B-1], t1,
                 s[SEG_A-2:0], t3};
    end
endmodule

// File: rtl/lfk_ctrl.sv
module lfk_ctrl
    import lfk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic en,
    output logic adv,
    output logic ready
);
    phase_e           ph;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else if (load) begin
            ph  <= PH_WARM;
            cnt <= '0;
        end else if (ph == PH_WARM) begin
            if (cnt == CNT_W'(WARMUP - 1)) ph <= PH_RUN;
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (ph == PH_RUN);
    assign adv   = !load && ((ph == PH_WARM) || (ready && en));

    // R9: a load always restarts the warm-up from its first clock
    a_r9_load_restarts: assert property (@(posedge clk) disable iff (rst)
        load |=> (ph == PH_WARM) && (cnt == '0));

    // R3: the last warm-up clock hands over to generation
    a_r3_warm_to_run: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WARM && !load && cnt == CNT_W'(WARMUP - 1)) |=> ready);

    // R3: no early exit from warm-up
    a_r3_no_early_run: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WARM && !load && cnt != CNT_W'(WARMUP - 1)) |=> !ready);
endmodule

// File: rtl/lfk_state.sv
module lfk_state
    import lfk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [KEY_W-1:0]  key,
    input  logic [IV_W-1:0]   iv,
    input  state_t            nxt,
    output state_t            q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= seed(key, iv);
        else if (adv)  q <= nxt;
    end

    // R4: a paused core keeps its state
    a_r4_hold_paused: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(q));

    // R2: constant ones land at the top of the last segment
    a_r2_seed_consts: assert property (@(posedge clk) disable iff (rst)
        load |=> (q[STATE_W-1 -: 3] == 3'b111) && (q[IV_POS-1:KEY_W] == '0));
endmodule

// File: rtl/lfk_core.sv
module lfk_core
    import lfk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [79:0]      key,
    input  logic [79:0]      iv,
    input  logic             load,
    input  logic             en,
    input  logic             lin_mode,
    input  logic             din,
    output logic             dout,
    output logic             ks_valid
);
    state_t st;
    step_t  stp;
    logic   adv, ready;

    lfk_ctrl i_ctrl (
        .clk(clk), .rst(rst), .load(load), .en(en),
        .adv(adv), .ready(ready)
    );

    lfk_state i_state (
        .clk(clk), .rst(rst), .load(load), .adv(adv),
        .key(key), .iv(iv), .nxt(stp.nxt), .q(st)
    );

    lfk_round i_round (
        .s(st), .lin(lin_mode), .o(stp)
    );

    assign ks_valid = ready && en && !load;
    assign dout     = ks_valid ? (din ^ stp.z) : 1'b0;

    // R1: reset silences the output
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !ks_valid && !dout);

    // R5: nothing leaves the core while it is not valid
    a_r5_no_stray_data: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !dout);
endmodule

// File: tb/test_lfk_core.sv
module test_lfk_core;
    localparam int NB   = 64;
    localparam int WARM = 1152;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [79:0] key = '0, iv = '0;
    logic        load = 1'b0, en = 1'b0, lin_mode = 1'b0, din = 1'b0;
    logic        dout, ks_valid;

    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lfk_core i_lfk_core (
        .clk(clk), .rst(rst), .key(key), .iv(iv), .load(load), .en(en),
        .lin_mode(lin_mode), .din(din), .dout(dout), .ks_valid(ks_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bit-accurate reference, positions 1..288
    function automatic logic [NB-1:0] ref_stream(input logic [79:0] k, input logic [79:0] v,
                                                  input bit lin, input int skip);
        logic [1:288] s;
        logic [NB-1:0] r;
        logic t1, t2, t3, z;
        s = '0;
        for (int i = 0; i < 80; i++) begin
            s[i+1]  = k[i];
            s[94+i] = v[i];
        end
        s[286] = 1; s[287] = 1; s[288] = 1;
        r = '0;
        for (int n = 0; n < WARM + skip + NB; n++) begin
            t1 = s[66] ^ s[93];
            t2 = s[162] ^ s[177];
            t3 = s[243] ^ s[288];
            z  = t1 ^ t2 ^ t3;
            t1 ^= (lin ? 1'b0 : (s[91] & s[92])) ^ s[171];
            t2 ^= (lin ? 1'b0 : (s[175] & s[176])) ^ s[264];
            t3 ^= (lin ? 1'b0 : (s[286] & s[287])) ^ s[69];
            for (int j = 288; j >= 2; j--) s[j] = s[j-1];
            s[1] = t3; s[94] = t1; s[178] = t2;
            if (n >= WARM + skip) r[n - WARM - skip] = z;
        end
        return r;
    endfunction

    // pulse load, then verify the 1152-cycle silent warm-up (R3)
    task automatic do_load(input logic [79:0] k, input logic [79:0] v, input bit lin);
        int early;
        @(negedge clk);
        key = k; iv = v; lin_mode = lin; load = 1'b1; en = 1'b1;
        @(negedge clk);
        load = 1'b0;
        early = 0;
        for (int i = 0; i < WARM; i++) begin
            #2;
            if (ks_valid) early++;
            @(negedge clk);
        end
        #2;
        chk(early == 0, "R3 warm-up silent", 64'(early), 64'd0);
        chk(ks_valid === 1'b1, "R3 valid after 1152", 64'(ks_valid), 64'd1);
    endtask

    // collect n bits starting at the current sample point; din pattern mixes in
    task automatic grab(input int n, input int seed, output logic [NB-1:0] ks);
        int bad = 0;
        ks = '0;
        for (int i = 0; i < n; i++) begin
            din = 1'((i * 7 + seed) % 3 == 0);
            en = 1'b1;
            #1;
            if (!ks_valid) bad++;
            ks[i] = dout ^ din;
            @(negedge clk); #2;
        end
        chk(bad == 0, "R4 valid while enabled", 64'(bad), 64'd0);
    endtask

    logic [NB-1:0] got, exp, sa, sb, sc, sd;
    logic [79:0] ka, kb, kc, va, vb, vc;

    initial begin
        // R1: reset and idle before any load
        repeat (3) @(negedge clk);
        #2;
        chk(ks_valid == 0 && dout == 0, "R1 reset state", {ks_valid, dout}, 0);
        @(negedge clk); rst = 1'b0; en = 1'b1; din = 1'b1;
        repeat (20) @(negedge clk);
        #2;
        chk(ks_valid == 0 && dout == 0, "R1 idle before load", {ks_valid, dout}, 0);

        // R6/R2: normal mode, several key/IV patterns
        do_load(80'h0123456789ABCDEF0123, 80'hFEDCBA9876543210FEDC, 0);
        grab(NB, 1, got);
        exp = ref_stream(80'h0123456789ABCDEF0123, 80'hFEDCBA9876543210FEDC, 0, 0);
        chk(got == exp, "R6 keystream pattern A", got, exp);

        do_load(80'h1, 80'h0, 0);
        grab(NB, 2, got);
        exp = ref_stream(80'h1, 80'h0, 0, 0);
        chk(got == exp, "R2 key bit0 placement", got, exp);

        do_load(80'h0, 80'h8000_0000_0000_0000_0000, 0);
        grab(NB, 0, got);
        exp = ref_stream(80'h0, 80'h8000_0000_0000_0000_0000, 0, 0);
        chk(got == exp, "R2 iv bit79 placement", got, exp);

        // R4: pause mid-stream, output silent, stream resumes in place
        do_load(80'hA5A5_5A5A_A5A5_5A5A_A5A5, 80'h3C3C_C3C3_3C3C_C3C3_3C3C, 0);
        grab(20, 0, got);
        en = 1'b0; din = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1;
            chk(ks_valid == 0 && dout == 0, "R4 paused output low", {ks_valid, dout}, 0);
            @(negedge clk); #2;
        end
        grab(NB, 0, got);
        exp = ref_stream(80'hA5A5_5A5A_A5A5_5A5A_A5A5, 80'h3C3C_C3C3_3C3C_C3C3_3C3C, 0, 20);
        chk(got == exp, "R4 resume after pause", got, exp);

        // R5: encrypt then decrypt with the same key/IV
        do_load(80'h77, 80'h99, 0);
        sa = '0;
        for (int i = 0; i < NB; i++) begin
            din = 1'(i % 5 == 1); en = 1'b1; #1;
            sa[i] = dout; @(negedge clk); #2;
        end
        do_load(80'h77, 80'h99, 0);
        sb = '0;
        for (int i = 0; i < NB; i++) begin
            din = sa[i]; en = 1'b1; #1;
            sb[i] = dout; @(negedge clk); #2;
        end
        exp = '0;
        for (int i = 0; i < NB; i++) exp[i] = 1'(i % 5 == 1);
        chk(sb == exp, "R5 decrypt recovers plaintext", sb, exp);

        // R7: fault mode matches linearized reference and differs from normal
        do_load(80'h0123456789ABCDEF0123, 80'hFEDCBA9876543210FEDC, 1);
        grab(NB, 3, got);
        exp = ref_stream(80'h0123456789ABCDEF0123, 80'hFEDCBA9876543210FEDC, 1, 0);
        chk(got == exp, "R7 fault-mode keystream", got, exp);
        sd = ref_stream(80'h0123456789ABCDEF0123, 80'hFEDCBA9876543210FEDC, 0, 0);
        chk(got != sd, "R7 fault mode alters stream", got, sd);

        // R8: GF(2) superposition in fault mode, two triples
        for (int t = 0; t < 2; t++) begin
            ka = {16'(t * 97 + 5), 64'hDEAD_BEEF_0BAD_F00D}; va = 80'h1357 << t;
            kb = 80'hCAFE_0000_1234 ^ 80'(t);                va = va ^ 80'h5;
            kc = {80{1'b1}} >> (t + 3);                      vb = 80'h2468_ACE0 << (t * 9);
            vc = ~80'h0 ^ 80'(t * 77);
            do_load(ka, va, 1); grab(NB, 0, sa);
            do_load(kb, vb, 1); grab(NB, 0, sb);
            do_load(kc, vc, 1); grab(NB, 0, sc);
            do_load(ka ^ kb ^ kc, va ^ vb ^ vc, 1); grab(NB, 0, sd);
            chk(sd == (sa ^ sb ^ sc), "R8 linear superposition", sd, sa ^ sb ^ sc);
        end

        // R9: reload during generation and during warm-up
        do_load(80'h42, 80'h24, 0);
        grab(10, 0, got);
        do_load(80'hBEEF, 80'hF00D, 0);
        grab(NB, 0, got);
        exp = ref_stream(80'hBEEF, 80'hF00D, 0, 0);
        chk(got == exp, "R9 reload during generation", got, exp);

        @(negedge clk);
        key = 80'h1111; iv = 80'h2222; lin_mode = 0; load = 1'b1;
        @(negedge clk); load = 1'b0;
        repeat (300) @(negedge clk);
        do_load(80'h3333, 80'h4444, 0);
        grab(NB, 0, got);
        exp = ref_stream(80'h3333, 80'h4444, 0, 0);
        chk(got == exp, "R9 reload during warm-up", got, exp);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule